// File: doc/BRIEF.md
# Eight-Stage Pipeline Load and Branch Interlock

This block decides, once per cycle, whether the front of an in-order eight-stage integer pipeline may advance. The stages are fetch 1, fetch 2, register fetch, execute, data fetch 1, data fetch 2, tag check and writeback. The instruction sitting in register fetch is presented on the `rf_*` inputs. The block keeps its own shadow record of the four stages from execute through tag check: valid bit, load flag, destination register, and the class of the instruction in execute. From that record it checks every hazard in register fetch.

ALU results are forwarded from execute onward without any penalty, so the block only produces forwarding select codes for them. Load data becomes usable once the load has left the second data-cache stage. A consumer directly behind a load therefore waits two cycles, and one that is two slots behind waits one cycle. While it waits, the three front stages hold and an invalid bubble enters execute. Branches resolve in execute. The instruction behind a branch is its single delay slot. The two sequentially fetched instructions in the fetch stages are squashed, which gives the three-cycle branch cost. A "likely" branch that resolves not-taken cancels its delay slot.

Top module: `pipe_interlock`

## Requirements
- R1: After reset, all shadow stages are empty. `hold_front`, `ex_bubble`, `front_squash` and `slot_annul` are 0, and both forward selects are 0, whatever the register-fetch inputs are.
- R2: A source that is unused or names register 0 never matches a producer. It never causes a hold, and its forward select stays 0.
- R3: A consumer in register fetch whose nearest producer is a valid load in execute holds the front for exactly 2 consecutive cycles. `ex_bubble` is high in each held cycle, and each held cycle sends an invalid bubble into execute.
- R4: When the nearest producer is a load in data fetch 1, the consumer holds for 1 cycle. When that load is in data fetch 2, the consumer does not hold and its select is 3.
- R5: Only the nearest producer of a register counts. A younger non-load writer of the same register shadows an older load, so there is no hold, and the select points at the younger writer.
- R6: The forward select of a source names the stage that holds its nearest valid producer with a matching nonzero destination: 0 = register file, 1 = execute, 2 = data fetch 1, 3 = data fetch 2, 4 = tag check. It is 0 when register fetch carries no live instruction.
- R7: `front_squash` is high exactly in the cycles in which a valid branch of class 2 or 3 occupies execute. This kills the two fetch-stage instructions behind the delay slot.
- R8: Class encoding: 0 = ALU, 1 = load, 2 = branch, 3 = likely branch. `slot_annul` is high when a valid likely branch is in execute and `ex_taken` is 0. The register-fetch instruction is then cancelled: it never holds the front, it enters execute as a bubble, and it is never a forwarding producer.
- R9: A taken likely branch, and any ordinary branch, never annuls its delay slot. Such a slot behaves like any other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_valid | input | 1 | Register-fetch stage holds an instruction |
| rf_kind | input | 2 | Class of that instruction (R8 encoding) |
| rf_dst | input | REG_W | Destination register, 0 if none |
| rf_src_a | input | REG_W | First source register |
| rf_src_b | input | REG_W | Second source register |
| rf_use_a | input | 1 | First source is read |
| rf_use_b | input | 1 | Second source is read |
| ex_taken | input | 1 | Branch in execute resolved taken |
| hold_front | output | 1 | Fetch 1, fetch 2 and register fetch keep their contents |
| ex_bubble | output | 1 | Execute receives an invalid bubble next cycle |
| front_squash | output | 1 | Kill the two fetch-stage instructions |
| slot_annul | output | 1 | Cancel the delay slot in register fetch |
| fwd_a_sel | output | 3 | Forward select for first source (R6 codes) |
| fwd_b_sel | output | 3 | Forward select for second source (R6 codes) |

## Verification
Directed sequences place a consumer zero, one and two slots behind a load. Together they separate the 2-cycle, 1-cycle and no-hold cases and show that a hold never runs past two cycles. Further directed sequences put a load behind register 0, shadow a load with a younger ALU writer, and load inside the delay slot of taken and not-taken likely branches and of an ordinary branch. These cases separate the nearest-producer rule, the rule that annulment overrides a hold, and the branch-class distinction. A long random stream over a narrow set of registers then mixes all classes and taken outcomes. It is compared each cycle against a bench model of the shadow stages built from the requirements.

// File: rtl/pipe_interlock.sv
module pipe_interlock #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_valid,
  input  logic [1:0]       rf_kind,
  input  logic [REG_W-1:0] rf_dst,
  input  logic [REG_W-1:0] rf_src_a,
  input  logic [REG_W-1:0] rf_src_b,
  input  logic             rf_use_a,
  input  logic             rf_use_b,
  input  logic             ex_taken,
  output logic             hold_front,
  output logic             ex_bubble,
  output logic             front_squash,
  output logic             slot_annul,
  output logic [2:0]       fwd_a_sel,
  output logic [2:0]       fwd_b_sel
);
  localparam int DEPTH = 4;

  logic [DEPTH-1:0] v_q, ld_q;
  logic [REG_W-1:0] dst_q [DEPTH];
  logic [1:0]       ex_kind_q;
  logic [2:0]       sel_a, sel_b;
  logic             live, hz_a, hz_b;

  assign slot_annul   = v_q[0] && ex_kind_q == 2'd3 && !ex_taken;
  assign front_squash = v_q[0] && ex_kind_q[1];
  assign live         = rf_valid && !slot_annul;

  always_comb begin
    sel_a = '0;
    sel_b = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (rf_use_a && rf_src_a != '0 && v_q[i] && dst_q[i] == rf_src_a) sel_a = 3'(i+1);
      if (rf_use_b && rf_src_b != '0 && v_q[i] && dst_q[i] == rf_src_b) sel_b = 3'(i+1);
    end
  end

  assign hz_a = (sel_a == 3'd1 && ld_q[0]) || (sel_a == 3'd2 && ld_q[1]);
  assign hz_b = (sel_b == 3'd1 && ld_q[0]) || (sel_b == 3'd2 && ld_q[1]);

  assign hold_front = live && (hz_a || hz_b);
  assign ex_bubble  = hold_front || slot_annul;
  assign fwd_a_sel  = live ? sel_a : 3'd0;
  assign fwd_b_sel  = live ? sel_b : 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q       <= '0;
      ld_q      <= '0;
      ex_kind_q <= '0;
      for (int i = 0; i < DEPTH; i++) dst_q[i] <= '0;
    end else begin
      v_q       <= {v_q[DEPTH-2:0], live && !hold_front};
      ld_q      <= {ld_q[DEPTH-2:0], rf_kind == 2'd1};
      ex_kind_q <= rf_kind;
      dst_q[0]  <= rf_dst;
      for (int i = 1; i < DEPTH; i++) dst_q[i] <= dst_q[i-1];
    end
  end

  // R3
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_front |=> !v_q[0]);

  // R3
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_front && $past(hold_front)) |=> !hold_front);

  // R8
  annul_nohold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_annul |-> !hold_front);

  // R8
  annul_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_annul |=> !v_q[0]);

  // R7
  annul_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_annul |-> front_squash);

  // R2
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_src_a == '0) |-> fwd_a_sel == 3'd0);
endmodule

// File: tb/pipe_interlock_test.sv
`timescale 1ns/1ps
module pipe_interlock_test;
  logic clk = 0, rst_n = 0;
  logic rf_valid = 0, rf_use_a = 0, rf_use_b = 0, ex_taken = 0;
  logic [1:0] rf_kind = 0;
  logic [4:0] rf_dst = 0, rf_src_a = 0, rf_src_b = 0;
  logic hold_front, ex_bubble, front_squash, slot_annul;
  logic [2:0] fwd_a_sel, fwd_b_sel;

  int nchk = 0, nerr = 0;
  logic mv[4], mld[4];
  logic [4:0] mdst[4];
  logic [1:0] mkind;
  logic e_stall, e_annul, saw_annul;

  always #5 clk = ~clk;

  pipe_interlock #(.REG_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .rf_valid(rf_valid), .rf_kind(rf_kind), .rf_dst(rf_dst),
    .rf_src_a(rf_src_a), .rf_src_b(rf_src_b), .rf_use_a(rf_use_a), .rf_use_b(rf_use_b),
    .ex_taken(ex_taken), .hold_front(hold_front), .ex_bubble(ex_bubble),
    .front_squash(front_squash), .slot_annul(slot_annul),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] near(input logic u, input logic [4:0] s);
    logic [2:0] r = 0;
    if (u && s != 0)
      for (int i = 3; i >= 0; i--) if (mv[i] && mdst[i] == s) r = 3'(i+1);
    return r;
  endfunction

  task automatic cyc(input logic v, input logic [1:0] k, input logic [4:0] d,
                     input logic [4:0] sa, input logic [4:0] sb,
                     input logic ua, input logic ub, input logic tk);
    logic live;
    logic [2:0] ea, eb;
    @(negedge clk);
    rf_valid = v; rf_kind = k; rf_dst = d; rf_src_a = sa; rf_src_b = sb;
    rf_use_a = ua; rf_use_b = ub; ex_taken = tk;
    #1;
    e_annul = mv[0] && mkind == 2'd3 && !tk;
    live = v && !e_annul;
    ea = live ? near(ua, sa) : 3'd0;
    eb = live ? near(ub, sb) : 3'd0;
    e_stall = live && ((ea == 1 && mld[0]) || (ea == 2 && mld[1]) ||
                       (eb == 1 && mld[0]) || (eb == 2 && mld[1]));
    if (slot_annul) saw_annul = 1;
    chk("R2/R3/R4/R5 hold_front", int'(hold_front), int'(e_stall));
    chk("R3/R8 ex_bubble", int'(ex_bubble), int'(e_stall || e_annul));
    chk("R7 front_squash", int'(front_squash), int'(mv[0] && mkind[1]));
    chk("R8/R9 slot_annul", int'(slot_annul), int'(e_annul));
    chk("R6 fwd_a_sel", int'(fwd_a_sel), int'(ea));
    chk("R6 fwd_b_sel", int'(fwd_b_sel), int'(eb));
    for (int i = 3; i > 0; i--) begin mv[i] = mv[i-1]; mld[i] = mld[i-1]; mdst[i] = mdst[i-1]; end
    mv[0] = live && !e_stall; mld[0] = (k == 2'd1); mdst[0] = d; mkind = k;
  endtask

  task automatic issue(input logic [1:0] k, input logic [4:0] d, input logic [4:0] sa,
                       input logic ua, input logic tk, output int stalls);
    stalls = 0;
    do begin
      cyc(1'b1, k, d, sa, 5'd0, ua, 1'b0, tk);
      if (e_stall) stalls++;
    end while (e_stall);
  endtask

  task automatic flush();
    for (int i = 0; i < 5; i++) cyc(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #1_500_000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int s;
    int unsigned seed;
    logic pend;
    logic [1:0] k;
    logic [4:0] d, sa, sb;
    logic ua, ub;
    for (int i = 0; i < 4; i++) begin mv[i] = 0; mld[i] = 0; mdst[i] = 0; end
    mkind = 0; saw_annul = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty pipeline, matching-looking inputs
    cyc(1'b1, 2'd1, 5'd5, 5'd5, 5'd5, 1'b1, 1'b1, 1'b0);
    chk("R1 hold_front after reset", int'(hold_front), 0);
    chk("R1 fwd_a_sel after reset", int'(fwd_a_sel), 0);
    flush();
    // R3
    issue(2'd1, 5'd5, 5'd1, 1'b1, 1'b0, s);
    issue(2'd0, 5'd9, 5'd5, 1'b1, 1'b0, s);
    chk("R3 adjacent load-use hold cycles", s, 2);
    flush();
    // R4 one between
    issue(2'd1, 5'd6, 5'd1, 1'b1, 1'b0, s);
    issue(2'd0, 5'd9, 5'd1, 1'b1, 1'b0, s);
    issue(2'd0, 5'd10, 5'd6, 1'b1, 1'b0, s);
    chk("R4 one-gap hold cycles", s, 1);
    flush();
    // R4 two between
    issue(2'd1, 5'd7, 5'd1, 1'b1, 1'b0, s);
    issue(2'd0, 5'd9, 5'd1, 1'b1, 1'b0, s);
    issue(2'd0, 5'd10, 5'd1, 1'b1, 1'b0, s);
    cyc(1'b1, 2'd0, 5'd11, 5'd7, 5'd0, 1'b1, 1'b0, 1'b0);
    chk("R4 two-gap select", int'(fwd_a_sel), 3);
    chk("R4 two-gap no hold", int'(hold_front), 0);
    flush();
    // R2
    issue(2'd1, 5'd0, 5'd1, 1'b1, 1'b0, s);
    issue(2'd0, 5'd9, 5'd0, 1'b1, 1'b0, s);
    chk("R2 register 0 never holds", s, 0);
    flush();
    // R5
    issue(2'd1, 5'd8, 5'd1, 1'b1, 1'b0, s);
    issue(2'd0, 5'd8, 5'd1, 1'b1, 1'b0, s);
    cyc(1'b1, 2'd0, 5'd12, 5'd8, 5'd0, 1'b1, 1'b0, 1'b0);
    chk("R5 younger writer shadows load, select", int'(fwd_a_sel), 1);
    chk("R5 younger writer shadows load, hold", int'(hold_front), 0);
    flush();
    // R8 likely not taken, load in slot annulled
    saw_annul = 0;
    issue(2'd3, 5'd0, 5'd1, 1'b1, 1'b0, s);
    issue(2'd1, 5'd10, 5'd1, 1'b1, 1'b0, s);
    chk("R8 annul seen", int'(saw_annul), 1);
    issue(2'd0, 5'd13, 5'd10, 1'b1, 1'b0, s);
    chk("R8 annulled slot is no producer", s, 0);
    flush();
    // R9 likely taken
    saw_annul = 0;
    issue(2'd3, 5'd0, 5'd1, 1'b1, 1'b0, s);
    issue(2'd1, 5'd11, 5'd1, 1'b1, 1'b1, s);
    issue(2'd0, 5'd13, 5'd11, 1'b1, 1'b0, s);
    chk("R9 taken likely slot kept", s, 2);
    chk("R9 no annul when taken", int'(saw_annul), 0);
    flush();
    // R9 ordinary branch not taken
    saw_annul = 0;
    issue(2'd2, 5'd0, 5'd1, 1'b1, 1'b0, s);
    issue(2'd1, 5'd14, 5'd1, 1'b1, 1'b0, s);
    issue(2'd0, 5'd13, 5'd14, 1'b1, 1'b0, s);
    chk("R9 ordinary branch slot kept", s, 2);
    chk("R9 ordinary branch no annul", int'(saw_annul), 0);
    flush();
    // R7/R8 branch held behind load, then annuls its slot
    issue(2'd1, 5'd12, 5'd1, 1'b1, 1'b0, s);
    issue(2'd3, 5'd0, 5'd12, 1'b1, 1'b0, s);
    chk("R3 branch waits on load", s, 2);
    issue(2'd1, 5'd15, 5'd12, 1'b1, 1'b0, s);
    chk("R8 annul overrides nothing to wait", s, 0);
    flush();
    // random
    seed = 32'd1234;
    void'($urandom(seed));
    pend = 0; k = 0; d = 0; sa = 0; sb = 0; ua = 0; ub = 0;
    for (int n = 0; n < 4000; n++) begin
      if (!pend) begin
        k = 2'($urandom_range(3)); d = 5'($urandom_range(7));
        sa = 5'($urandom_range(7)); sb = 5'($urandom_range(7));
        ua = 1'($urandom_range(1)); ub = 1'($urandom_range(1));
      end
      cyc(!pend ? ($urandom_range(7) != 0) : 1'b1, k, d, sa, sb, ua, ub, 1'($urandom_range(1)));
      pend = e_stall;
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule